// File: doc/BRIEF.md
# Paged Sensor Register Sequencer

This block serves a camera sensor whose 16-bit registers sit in selectable pages and can only be reached through 8-bit register, 8-bit data serial-bus transfers. A host hands the block one command: a direction flag, a 16-bit page number, an 8-bit register index and, for writes, a 16-bit value. The block turns that command into exactly four single-byte requests to a byte-wide serial-bus transaction engine, one at a time, over a request/acknowledge handshake. For reads it joins the two returned bytes into one 16-bit result.

The first two requests always select the page: the upper page byte goes to register 0xF0 and the lower page byte goes to register 0xF1. The third request reaches the target register index and carries the high data byte. The fourth request goes through the fixed low-byte alias register 0xF1 and carries the low data byte. If the engine reports a missing acknowledge on the bus, the command ends at once and is flagged as failed. The block also divides the system clock down to the sensor's master clock, which is 25 MHz from a 100 MHz system clock by default.

Top module: `sensor_page_seq`

## Requirements
- R1: One cycle after an active-high synchronous reset, cmd_ready is 1 and bx_req, done and mclk_out are all 0.
- R2: Every command starts with two write requests: first addr 0xF0 with data page[15:8], then addr 0xF1 with data page[7:0]. For a write request, bx_write is 1.
- R3: For a write command (cmd_write=1), request three writes wdata[15:8] to the register index and request four writes wdata[7:0] to 0xF1. After a write command, rd_data is 0x0000.
- R4: For a read command (cmd_write=0), request three reads the register index and request four reads 0xF1. bx_write is 0 and bx_wdata is 0x00 on both. In the done cycle, rd_data equals {byte returned by request three, byte returned by request four}.
- R5: bx_dev equals the DEV_ADDR parameter (default 7'h48) on every request.
- R6: cmd_ready is 0 from the cycle after acceptance through the done cycle. done is high for exactly one cycle, which is the cycle after the final acknowledge. cmd_ready is 1 again in the cycle after done.
- R7: bx_req stays high with stable bx_addr, bx_wdata and bx_write until bx_ack. After a non-final, non-failed acknowledge, the next request is presented in the very next cycle.
- R8: An acknowledge with bx_nack=1 ends the command: done and err are 1 in the next cycle and no further request is issued. A command that completes all four requests has err=0.
- R9: mclk_out toggles every SYS_CLK_HZ/(2*MCLK_HZ) cycles, which is a 4-cycle period by default.
- R10: cmd_valid and the command fields are ignored while a command is in progress. The bytes sent come only from the values captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_page | input | 16 | Page number to select |
| cmd_reg | input | 8 | Target register index |
| cmd_wdata | input | 16 | Value to write (0x0000 for reads) |
| done | output | 1 | One-cycle pulse when the command ends |
| err | output | 1 | Command ended on a missing acknowledge; valid with done |
| rd_data | output | 16 | Read result; valid with done |
| bx_req | output | 1 | Byte transaction request |
| bx_ack | input | 1 | One-cycle completion pulse from the byte engine |
| bx_nack | input | 1 | Missing acknowledge on the bus; valid with bx_ack |
| bx_write | output | 1 | 1 = byte write, 0 = byte read |
| bx_dev | output | 7 | Serial-bus device address |
| bx_addr | output | 8 | Byte register address |
| bx_wdata | output | 8 | Byte to write |
| bx_rdata | input | 8 | Byte read back; valid with bx_ack |
| mclk_out | output | 1 | Divided sensor master clock |

## Verification
The sequence is exercised with write and read commands that use distinct page bytes and data bytes. This catches swapped page halves, swapped data halves and a wrong alias address. Engine latencies of zero and several cycles separate a correct hold-until-acknowledge from a request that moves early or stalls. Missing acknowledges on the first and the third request check that the sequence stops at the right point and that a later command still runs. Command inputs are changed mid-command to show that only the values captured at acceptance reach the bus.

// File: rtl/sensor_page_seq_pkg.sv
package sensor_page_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NUM_STEPS = 4;
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam logic [BYTE_W-1:0] PAGE_HI_REG = 8'hF0;
  localparam logic [BYTE_W-1:0] LOW_ALIAS_REG = 8'hF1;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_FIN} seqState_t;

  typedef struct packed {
    logic              load;
    logic              capHi;
    logic              capLo;
    logic [STEP_W-1:0] step;
  } dpCtl_t;
endpackage

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sensor_page_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cmdValid,
  input  logic   bxAck,
  input  logic   bxNack,
  output logic   cmdReady,
  output logic   bxReq,
  output logic   doneOut,
  output logic   errOut,
  output dpCtl_t ctl
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [STEP_W-1:0] HI_STEP   = STEP_W'(NUM_STEPS - 2);

  seqState_t         stateQ;
  logic [STEP_W-1:0] stepQ;
  logic              errQ;
  logic              goodAck;

  assign goodAck = (stateQ == ST_BUSY) && bxAck && !bxNack;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
      errQ   <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (cmdValid) begin
          stateQ <= ST_BUSY;
          stepQ  <= '0;
          errQ   <= 1'b0;
        end
        ST_BUSY: if (bxAck) begin
          if (bxNack) begin
            stateQ <= ST_FIN;
            errQ   <= 1'b1;
          end else if (stepQ == LAST_STEP) begin
            stateQ <= ST_FIN;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign cmdReady  = (stateQ == ST_IDLE);
  assign bxReq     = (stateQ == ST_BUSY);
  assign doneOut   = (stateQ == ST_FIN);
  assign errOut    = errQ;
  assign ctl.load  = cmdReady && cmdValid;
  assign ctl.capHi = goodAck && (stepQ == HI_STEP);
  assign ctl.capLo = goodAck && (stepQ == LAST_STEP);
  assign ctl.step  = stepQ;
endmodule

// File: rtl/sps_dp.sv
module sps_dp
  import sensor_page_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic              cmdWrite,
  input  logic [WORD_W-1:0] cmdPage,
  input  logic [BYTE_W-1:0] cmdReg,
  input  logic [WORD_W-1:0] cmdWdata,
  input  logic [BYTE_W-1:0] bxRdata,
  output logic              bxWrite,
  output logic [BYTE_W-1:0] bxAddr,
  output logic [BYTE_W-1:0] bxWdata,
  output logic [WORD_W-1:0] rdData
);
  logic              isWriteQ;
  logic [WORD_W-1:0] pageQ;
  logic [WORD_W-1:0] wdataQ;
  logic [BYTE_W-1:0] regQ;
  logic [BYTE_W-1:0] hiQ;
  logic [BYTE_W-1:0] loQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      isWriteQ <= 1'b0;
      pageQ    <= '0;
      wdataQ   <= '0;
      regQ     <= '0;
      hiQ      <= '0;
      loQ      <= '0;
    end else if (ctl.load) begin
      isWriteQ <= cmdWrite;
      pageQ    <= cmdPage;
      wdataQ   <= cmdWrite ? cmdWdata : '0;
      regQ     <= cmdReg;
      hiQ      <= '0;
      loQ      <= '0;
    end else begin
      if (ctl.capHi && !isWriteQ) hiQ <= bxRdata;
      if (ctl.capLo && !isWriteQ) loQ <= bxRdata;
    end
  end

  always_comb begin
    case (ctl.step)
      2'd0: begin
        bxAddr  = PAGE_HI_REG;
        bxWdata = pageQ[WORD_W-1:BYTE_W];
        bxWrite = 1'b1;
      end
      2'd1: begin
        bxAddr  = LOW_ALIAS_REG;
        bxWdata = pageQ[BYTE_W-1:0];
        bxWrite = 1'b1;
      end
      2'd2: begin
        bxAddr  = regQ;
        bxWdata = wdataQ[WORD_W-1:BYTE_W];
        bxWrite = isWriteQ;
      end
      default: begin
        bxAddr  = LOW_ALIAS_REG;
        bxWdata = wdataQ[BYTE_W-1:0];
        bxWrite = isWriteQ;
      end
    endcase
  end

  assign rdData = {hiQ, loQ};
endmodule

// File: rtl/sps_mclk_div.sv
module sps_mclk_div #(
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int MCLK_HZ    = 25_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic mclk
);
  localparam int RATIO = SYS_CLK_HZ / (2 * MCLK_HZ);
  localparam int HALF  = (RATIO < 1) ? 1 : RATIO;
  localparam int CW    = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
      mclk <= 1'b0;
    end else if (cntQ == CW'(HALF - 1)) begin
      cntQ <= '0;
      mclk <= ~mclk;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/sensor_page_seq.sv
module sensor_page_seq
  import sensor_page_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h48,
  parameter int         SYS_CLK_HZ = 100_000_000,
  parameter int         MCLK_HZ    = 25_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_write,
  input  logic [15:0] cmd_page,
  input  logic [7:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        done,
  output logic        err,
  output logic [15:0] rd_data,
  output logic        bx_req,
  input  logic        bx_ack,
  input  logic        bx_nack,
  output logic        bx_write,
  output logic [6:0]  bx_dev,
  output logic [7:0]  bx_addr,
  output logic [7:0]  bx_wdata,
  input  logic [7:0]  bx_rdata,
  output logic        mclk_out
);
  dpCtl_t ctl;

  sps_ctrl ctrl_i (
    .clk(clk), .rst(rst), .cmdValid(cmd_valid), .bxAck(bx_ack), .bxNack(bx_nack),
    .cmdReady(cmd_ready), .bxReq(bx_req), .doneOut(done), .errOut(err), .ctl(ctl)
  );

  sps_dp dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .cmdWrite(cmd_write), .cmdPage(cmd_page),
    .cmdReg(cmd_reg), .cmdWdata(cmd_wdata), .bxRdata(bx_rdata),
    .bxWrite(bx_write), .bxAddr(bx_addr), .bxWdata(bx_wdata), .rdData(rd_data)
  );

  sps_mclk_div #(.SYS_CLK_HZ(SYS_CLK_HZ), .MCLK_HZ(MCLK_HZ)) mclk_i (
    .clk(clk), .rst(rst), .mclk(mclk_out)
  );

  assign bx_dev = DEV_ADDR;
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_ready,
  input logic       done,
  input logic       err,
  input logic       bx_req,
  input logic       bx_ack,
  input logic       bx_nack,
  input logic       bx_write,
  input logic [7:0] bx_addr,
  input logic [7:0] bx_wdata
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cmd_ready && !bx_req && !done));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (bx_req && !bx_ack) |=> (bx_req && $stable(bx_addr) && $stable(bx_wdata) && $stable(bx_write)));

  p_busy_not_ready_r6: assert property (@(posedge clk) disable iff (rst)
    bx_req |-> !cmd_ready);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && cmd_ready));

  p_nack_stops_r8: assert property (@(posedge clk) disable iff (rst)
    (bx_req && bx_ack && bx_nack) |=> (done && err && !bx_req));
endmodule

bind sensor_page_seq sps_checker chk_i (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .done(done), .err(err),
  .bx_req(bx_req), .bx_ack(bx_ack), .bx_nack(bx_nack), .bx_write(bx_write),
  .bx_addr(bx_addr), .bx_wdata(bx_wdata)
);

// File: tb/sensor_page_seq_tb_top.sv
module sensor_page_seq_tb_top;
  localparam logic [6:0] DEV = 7'h48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_page = '0, cmd_wdata = '0;
  logic [7:0] cmd_reg = '0, bx_rdata = '0;
  logic bx_ack = 1'b0, bx_nack = 1'b0;
  logic cmd_ready, done, err, bx_req, bx_write, mclk_out;
  logic [15:0] rd_data;
  logic [6:0] bx_dev;
  logic [7:0] bx_addr, bx_wdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sensor_page_seq #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_page(cmd_page), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .done(done), .err(err), .rd_data(rd_data), .bx_req(bx_req), .bx_ack(bx_ack),
    .bx_nack(bx_nack), .bx_write(bx_write), .bx_dev(bx_dev), .bx_addr(bx_addr),
    .bx_wdata(bx_wdata), .bx_rdata(bx_rdata), .mclk_out(mclk_out)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expAddr(input int i, input logic [7:0] ra);
    return (i == 0) ? 8'hF0 : (i == 2) ? ra : 8'hF1;
  endfunction

  function automatic logic [7:0] expData(input int i, input bit wr,
                                         input logic [15:0] pg, input logic [15:0] wd);
    case (i)
      0: return pg[15:8];
      1: return pg[7:0];
      2: return wr ? wd[15:8] : 8'h00;
      default: return wr ? wd[7:0] : 8'h00;
    endcase
  endfunction

  // Runs one command; nackAt < 0 means every request is acknowledged cleanly.
  task automatic runCmd(input bit wr, input logic [15:0] pg, input logic [7:0] ra,
                        input logic [15:0] wd, input int nackAt, input int lat,
                        input logic [7:0] hi, input logic [7:0] lo);
    logic [7:0] aLog[4];
    logic [7:0] dLog[4];
    logic       wLog[4];
    int nTx = 0;
    int expTx;
    bit failed;
    @(negedge clk);
    check(cmd_ready === 1'b1, "R6", "ready before command", {31'd0, cmd_ready}, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_page = pg; cmd_reg = ra; cmd_wdata = wd;
    @(negedge clk);
    check(cmd_ready === 1'b0, "R6", "ready after accept", {31'd0, cmd_ready}, 0);
    // R10: scramble inputs and keep offering while busy
    cmd_write = ~wr; cmd_page = ~pg; cmd_reg = ~ra; cmd_wdata = ~wd;
    for (int i = 0; i < 4; i++) begin
      int w = 0;
      bit last;
      while (!bx_req && w < 50) begin @(negedge clk); w++; end
      if (i > 0) check(w == 0, "R7", "gap before next request", w, 0);
      aLog[i] = bx_addr; dLog[i] = bx_wdata; wLog[i] = bx_write;
      check(bx_dev == DEV, "R5", "device address", {25'd0, bx_dev}, {25'd0, DEV});
      for (int l = 0; l < lat; l++) begin
        @(negedge clk);
        check(bx_req && bx_addr == aLog[i] && bx_wdata == dLog[i] && bx_write == wLog[i],
              "R7", "request held while waiting", {bx_req, bx_addr, bx_wdata}, {1'b1, aLog[i], dLog[i]});
      end
      bx_ack = 1'b1;
      bx_nack = (i == nackAt);
      bx_rdata = (i == 2) ? hi : (i == 3) ? lo : 8'h5A;
      nTx++;
      last = (i == nackAt) || (i == 3);
      if (last) cmd_valid = 1'b0;
      @(negedge clk);
      bx_ack = 1'b0; bx_nack = 1'b0;
      if (last) break;
    end
    failed = (nackAt >= 0 && nackAt < 4);
    expTx = failed ? nackAt + 1 : 4;
    check(done === 1'b1, "R6", "done after final ack", {31'd0, done}, 1);
    check(err === failed, "R8", "err flag", {31'd0, err}, {31'd0, failed});
    check(!bx_req, "R8", "no request in done cycle", {31'd0, bx_req}, 0);
    check(nTx == expTx, "R8", "transaction count", nTx, expTx);
    if (!failed) begin
      if (wr) check(rd_data == 16'h0000, "R3", "rd_data after write", rd_data, 0);
      else    check(rd_data == {hi, lo}, "R4", "read result", rd_data, {hi, lo});
    end
    for (int i = 0; i < nTx; i++) begin
      logic [7:0] ea = expAddr(i, ra);
      logic [7:0] ed = expData(i, wr, pg, wd);
      logic       ew = (i < 2) ? 1'b1 : wr;
      string rq = (i < 2) ? "R2" : (wr ? "R3" : "R4");
      check(aLog[i] == ea, rq, $sformatf("step %0d addr (R10)", i), aLog[i], ea);
      check(dLog[i] == ed, rq, $sformatf("step %0d data (R10)", i), dLog[i], ed);
      check(wLog[i] == ew, rq, $sformatf("step %0d direction", i), wLog[i], ew);
    end
    @(negedge clk);
    check(done === 1'b0, "R6", "done lasts one cycle", {31'd0, done}, 0);
    check(cmd_ready === 1'b1, "R6", "ready after done", {31'd0, cmd_ready}, 1);
    check(!bx_req, "R10", "no extra command from held valid", {31'd0, bx_req}, 0);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(cmd_ready === 1'b1 && bx_req === 1'b0 && done === 1'b0 && mclk_out === 1'b0,
          "R1", "idle after reset", {cmd_ready, bx_req, done, mclk_out}, 4'b1000);
  endtask

  task automatic testMclk();
    logic s[16];
    for (int i = 0; i < 16; i++) begin @(negedge clk); s[i] = mclk_out; end
    for (int i = 0; i < 12; i++) begin
      check(s[i] != s[i+2], "R9", "toggles every 2 cycles", {31'd0, s[i+2]}, {31'd0, ~s[i]});
      check(s[i] == s[i+4], "R9", "period of 4 cycles", {31'd0, s[i+4]}, {31'd0, s[i]});
    end
  endtask

  initial begin
    testReset();
    runCmd(1'b1, 16'h0000, 8'h20, 16'hA55A, -1, 1, 8'h00, 8'h00);
    runCmd(1'b0, 16'h0001, 8'h3C, 16'h0000, -1, 3, 8'h12, 8'hEF);
    runCmd(1'b1, 16'h0002, 8'h07, 16'hFF00, -1, 0, 8'h00, 8'h00);
    runCmd(1'b0, 16'h0102, 8'hC4, 16'h0000, -1, 0, 8'h9B, 8'h64);
    runCmd(1'b1, 16'h0001, 8'h11, 16'h1234, 0, 2, 8'h00, 8'h00);
    runCmd(1'b0, 16'h0002, 8'h50, 16'h0000, 2, 1, 8'hAA, 8'hBB);
    runCmd(1'b0, 16'h0000, 8'h0D, 16'h0000, -1, 1, 8'h80, 8'h01);
    testMclk();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule